// File: doc/BRIEF.md
# Three-Way Majority Voter with Discrepancy Code

This block receives the words produced by three identical processing units and forms their bitwise majority. With the voted word it produces a 3-bit code that says whether the units agree, which single unit disagrees, whether two or more disagree, or whether voting is turned off. A supervising controller uses the code to decide how to react, and host software can read it.

The voted word and the code are registered together. Each accepted input gives a result one cycle later, marked by a valid output. When the enable input is low, the voter keeps its last voted word and reports the disabled code. The data inputs have no effect on the output while the enable is low.

Top module: `majority_voter`

## Requirements
- R1: When enabled, the voted output of an accepted input is its bitwise majority: each output bit is 1 when at least two of the three input bits are 1.
- R2: When enabled and all three input words are equal, the fault code is 3'b000.
- R3: When enabled and exactly one unit's word differs from the voted word, the fault code is one-hot with bit 0 for unit A, bit 1 for unit B and bit 2 for unit C (3'b001, 3'b010, 3'b100).
- R4: When enabled and two or more unit words differ from the voted word in at least one bit, the fault code is 3'b111.
- R5: While the enable is low, the fault code becomes 3'b101 on the next clock edge, whatever the data inputs are.
- R6: While the enable is low, the voted output keeps its previous value.
- R7: The valid output follows the valid input by one cycle. The voted word and the code for that input appear in that same cycle. When enabled with no valid input, both keep their values.
- R8: With a data width of one bit, the code 3'b111 is never produced.
- R9: While synchronous reset is active, the voted output is 0, the fault code is 3'b000 and the valid output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vote_en | input | 1 | Voting enable; low selects the disabled state |
| in_valid | input | 1 | The three unit words are valid this cycle |
| unit_a | input | WIDTH | Word from unit A |
| unit_b | input | WIDTH | Word from unit B |
| unit_c | input | WIDTH | Word from unit C |
| vote_out | output | WIDTH | Registered bitwise majority word |
| fault_code | output | 3 | Registered discrepancy code |
| out_valid | output | 1 | Result registered from a valid input |

## Verification
Two functions can act in the same cycle: a valid input can arrive while the enable is low. In that case the disabled state must win. The code must read 101, and the output must keep the old voted word, even though a valid output still appears. The bench drives valid words that disagree during disabled stretches, and also changes the enable and offers a new word in the same cycle. A scoreboard model, which carries its own held word, judges each result. A second instance with a width of one bit is driven through all eight input patterns to confirm that code 111 never appears.

// File: rtl/mv_pkg.sv
// Package: shared code values and helpers for the majority voter.
// Assumes: fault code is always 3 bits wide.
package mv_pkg;

    localparam int CODE_W = 3;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_AGREE    = 3'b000;
    localparam code_t CODE_UNIT_A   = 3'b001;
    localparam code_t CODE_UNIT_B   = 3'b010;
    localparam code_t CODE_UNIT_C   = 3'b100;
    localparam code_t CODE_MULTI    = 3'b111;
    localparam code_t CODE_DISABLED = 3'b101;

    // Map a per-unit mismatch vector (bit0 = A) to a fault code.
    function automatic code_t encode_code(input logic [2:0] mism);
        code_t res;
        case ($countones(mism))
            0:       res = CODE_AGREE;
            1:       res = code_t'(mism);
            default: res = CODE_MULTI;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/mv_bit_majority.sv
// Module: bitwise two-of-three majority over WIDTH bits.
// Assumes: purely combinational; one independent voter per bit lane.
module mv_bit_majority #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    output logic [WIDTH-1:0] maj
);

    // One voter lane per bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic [1:0] ones;
        // Count ones in this lane and decide the majority.
        always_comb begin
            ones     = 2'(in_a[g]) + 2'(in_b[g]) + 2'(in_c[g]);
            maj[g]   = (ones >= 2'd2);
        end
    end

endmodule

// File: rtl/mv_discrepancy.sv
// Module: flags which units disagree with the voted word and encodes the code.
// Assumes: maj is the bitwise majority of the same three words.
module mv_discrepancy
    import mv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    input  logic [WIDTH-1:0] maj,
    output code_t            code
);

    logic [2:0] mism;

    // A unit is discrepant when any bit differs from the voted word.
    always_comb begin
        mism[0] = |(in_a ^ maj);
        mism[1] = |(in_b ^ maj);
        mism[2] = |(in_c ^ maj);
    end

    // Turn the mismatch vector into the reported code.
    always_comb code = encode_code(mism);

endmodule

// File: rtl/mv_out_stage.sv
// Module: output register for voted word, code and valid.
// Assumes: synchronous active-low reset; disabled state overrides loads.
module mv_out_stage
    import mv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] maj_in,
    input  code_t            code_in,
    output logic [WIDTH-1:0] word_q,
    output code_t            code_q,
    output logic             valid_q
);

    // Register the result; hold the word while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            code_q  <= CODE_AGREE;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (!en) begin
                code_q <= CODE_DISABLED;
            end else if (load) begin
                word_q <= maj_in;
                code_q <= code_in;
            end
        end
    end

endmodule

// File: rtl/majority_voter.sv
// Module: three-way majority voter with a registered discrepancy code.
// Assumes: WIDTH >= 1; inputs are synchronous to clk.
module majority_voter
    import mv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vote_en,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] unit_a,
    input  logic [WIDTH-1:0] unit_b,
    input  logic [WIDTH-1:0] unit_c,
    output logic [WIDTH-1:0] vote_out,
    output logic [2:0]       fault_code,
    output logic             out_valid
);

    logic [WIDTH-1:0] maj;
    code_t            code_c;
    code_t            code_r;

    mv_bit_majority #(.WIDTH(WIDTH)) u_maj (
        .in_a (unit_a),
        .in_b (unit_b),
        .in_c (unit_c),
        .maj  (maj)
    );

    mv_discrepancy #(.WIDTH(WIDTH)) u_disc (
        .in_a (unit_a),
        .in_b (unit_b),
        .in_c (unit_c),
        .maj  (maj),
        .code (code_c)
    );

    mv_out_stage #(.WIDTH(WIDTH)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (vote_en),
        .load    (in_valid),
        .maj_in  (maj),
        .code_in (code_c),
        .word_q  (vote_out),
        .code_q  (code_r),
        .valid_q (out_valid)
    );

    // Present the registered code on the port.
    always_comb fault_code = code_r;

endmodule

// File: rtl/majority_voter_chk.sv
// Checker: temporal properties of the majority voter, bound to every instance.
// Assumes: synchronous active-low reset.
module majority_voter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vote_en,
    input logic             in_valid,
    input logic [WIDTH-1:0] unit_a,
    input logic [WIDTH-1:0] unit_b,
    input logic [WIDTH-1:0] unit_c,
    input logic [WIDTH-1:0] vote_out,
    input logic [2:0]       fault_code,
    input logic             out_valid
);

    logic live;

    // Mark cycles that have a non-reset cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R1: enabled valid input yields the lane-wise two-of-three result.
    a_r1_majority: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(vote_en) && $past(in_valid)) |->
        vote_out == (($past(unit_a) & $past(unit_b)) | ($past(unit_a) & $past(unit_c))
                   | ($past(unit_b) & $past(unit_c))));

    // R5: disabled state reports 101.
    a_r5_disabled_code: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(vote_en)) |-> fault_code == 3'b101);

    // R6: disabled state holds the word.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(vote_en)) |-> $stable(vote_out));

    // R7: valid output follows valid input by one cycle.
    a_r7_valid: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> out_valid == $past(in_valid));

    // R3: only legal code values appear.
    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_code) || fault_code == 3'b111 || fault_code == 3'b101);

    // R8: one-bit voter never reports multi-unit disagreement.
    if (WIDTH == 1) begin : g_w1
        a_r8_no_multi: assert property (@(posedge clk) disable iff (!rst_n)
            fault_code != 3'b111);
    end

endmodule

bind majority_voter majority_voter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_majority_voter.sv
module tb_majority_voter;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vote_en = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] unit_a = '0, unit_b = '0, unit_c = '0;
    logic [W-1:0] vote_out;
    logic [2:0]   fault_code;
    logic         out_valid;

    logic         w1_en = 1'b1, w1_v = 1'b0, w1_a = 1'b0, w1_b = 1'b0, w1_c = 1'b0;
    logic         w1_out, w1_ov;
    logic [2:0]   w1_code;

    int checks = 0;
    int errors = 0;

    typedef struct packed { logic [W-1:0] word; logic [2:0] code; } exp_t;
    exp_t sb[$];
    logic [W-1:0] model_word = '0;
    logic [2:0]   model_code = 3'b000;

    always #10 clk = ~clk;

    majority_voter #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .vote_en(vote_en), .in_valid(in_valid),
        .unit_a(unit_a), .unit_b(unit_b), .unit_c(unit_c),
        .vote_out(vote_out), .fault_code(fault_code), .out_valid(out_valid));

    majority_voter #(.WIDTH(1)) dut_w1 (
        .clk(clk), .rst_n(rst_n), .vote_en(w1_en), .in_valid(w1_v),
        .unit_a(w1_a), .unit_b(w1_b), .unit_c(w1_c),
        .vote_out(w1_out), .fault_code(w1_code), .out_valid(w1_ov));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_code(input logic [W-1:0] a, b, c);
        logic [W-1:0] m;
        logic da, db, dc;
        m  = (a & b) | (b & c) | (a & c);
        da = (a != m); db = (b != m); dc = (c != m);
        case ({dc, db, da})
            3'b000:  return 3'b000;
            3'b001:  return 3'b001;
            3'b010:  return 3'b010;
            3'b100:  return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic drive(input logic en, input logic v, input logic [W-1:0] a, b, c);
        @(negedge clk);
        vote_en = en; in_valid = v; unit_a = a; unit_b = b; unit_c = c;
        if (!en) model_code = 3'b101;
        else if (v) begin
            model_word = (a & b) | (b & c) | (a & c);
            model_code = ref_code(a, b, c);
        end
        if (v) sb.push_back('{word: model_word, code: model_code});
    endtask

    // Monitor: compare each valid result with the scoreboard head (R1-R7 items).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) check("R7 unexpected out_valid", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = sb.pop_front();
                check("R1/R6 voted word", 32'(vote_out), 32'(e.word));
                check("R2/R3/R4/R5 fault code", 32'(fault_code), 32'(e.code));
            end
        end
    end

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9 vote_out", 32'(vote_out), 32'd0);
        check("R9 fault_code", 32'(fault_code), 32'd0);
        check("R9 out_valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        drive(1, 1, 8'h5A, 8'h5A, 8'h5A);   // R2 agree
        drive(1, 1, 8'h5B, 8'h5A, 8'h5A);   // R3 unit A
        drive(1, 1, 8'h3C, 8'hBC, 8'h3C);   // R3 unit B
        drive(1, 1, 8'hF0, 8'hF0, 8'h00);   // R3 unit C
        drive(1, 1, 8'h00, 8'hFF, 8'h0F);   // R4 two differ
        drive(1, 1, 8'h01, 8'h02, 8'h04);   // R4 all differ, R1 result 0
        drive(1, 1, 8'hC3, 8'hA5, 8'h99);   // R1 mixed lanes
        // R7: enabled, no valid -> both hold.
        drive(1, 0, 8'hFF, 8'hFF, 8'hFF);
        @(negedge clk);
        check("R7 hold word", 32'(vote_out), 32'(model_word));
        check("R7 hold code", 32'(fault_code), 32'(model_code));
        check("R7 no valid", 32'(out_valid), 32'd0);
        // R5/R6: valid data while disabled, same cycle as enable drop.
        drive(0, 1, 8'hFF, 8'h00, 8'h12);
        drive(0, 1, 8'h77, 8'h77, 8'h77);
        drive(0, 0, 8'h11, 8'h22, 8'h44);
        @(negedge clk);
        check("R5 idle disabled code", 32'(fault_code), 32'h5);
        check("R6 idle disabled word", 32'(vote_out), 32'(model_word));
        // Re-enable in same cycle as a valid input.
        drive(1, 1, 8'h81, 8'h81, 8'h80);
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] ra, rb, rc;
            ra = W'($urandom); rb = (i % 3 == 0) ? ra : W'($urandom);
            rc = (i % 4 == 0) ? ra : W'($urandom);
            drive((i % 7) != 3, (i % 5) != 2, ra, rb, rc);
        end
        drive(1, 0, '0, '0, '0);
        drive(1, 0, '0, '0, '0);
        check("R7 scoreboard drained", 32'(sb.size()), 32'd0);

        // R8: exhaustive one-bit voter.
        for (int p = 0; p < 8; p++) begin
            logic [2:0] ex;
            @(negedge clk);
            {w1_c, w1_b, w1_a} = 3'(p); w1_v = 1'b1;
            ex = (p == 0 || p == 7) ? 3'b000 :
                 (p == 1 || p == 6) ? 3'b001 :
                 (p == 2 || p == 5) ? 3'b010 : 3'b100;
            @(negedge clk);
            w1_v = 1'b0;
            check("R8 one-bit code", 32'(w1_code), 32'(ex));
            check("R8 one-bit word", 32'(w1_out), 32'($countones(3'(p)) >= 2));
            check("R8 no 111", 32'(w1_code == 3'b111), 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule